// File: doc/BRIEF.md
# Program and Data Address Generator

This unit forms the one memory address that a DSP core puts out to its bus components each cycle. It keeps three pointers: a derived-address register for computed operand addresses, an instruction pointer, and a prefetch pointer that runs ahead of the instruction pointer. A fourth candidate, the value held in the bus input data register, comes in from outside. A registered output mux picks one of the four according to the kind of access the core is making.

The derived-address register and the instruction pointer share a single incrementer, because in normal operation they never both need incrementing in the same cycle. If both requests do arrive together, the instruction pointer is served, the derived-address register holds its value, and an error flag is raised for one cycle. The prefetch pointer has its own small incrementer. Every pointer is `AW` bits wide (16 by default) and wraps modulo 2^AW.

Top module: `agu_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the derived-address register, instruction pointer and prefetch pointer are zero, `addr_out` is zero (the prefetch pointer's value), and `inc_err` is low.
- R2: `at_op` controls the derived-address register at each rising edge: 0 holds, 1 loads `sbus_val`, 2 loads its previous value plus one, 3 loads `din_val`.
- R3: `ip_op` controls the instruction pointer at each rising edge: 1 loads `sbus_val`, 2 loads its previous value plus one, 0 and 3 hold.
- R4: `pf_op` controls the prefetch pointer at each rising edge: 1 copies the instruction pointer's value from before that edge, 2 loads its previous value plus one, 0 and 3 hold.
- R5: At each rising edge `addr_out` takes the source picked by `acc_type` as it stood before that edge's register update: 0 (effective address) the derived-address register, 1 (jump) the instruction pointer, 2 (indirect) `din_val`, 3 (prefetch) the prefetch pointer.
- R6: Incrementing any pointer holding 2^AW-1 gives zero.
- R7: When `at_op` is 2 and `ip_op` is 2 in the same cycle, the instruction pointer increments, the derived-address register holds, and `inc_err` is high for the following cycle only; `inc_err` is low after any cycle without both requests.
- R8: Codes 3 of `ip_op` and `pf_op` leave the instruction pointer and prefetch pointer unchanged, as observed through `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sbus_val | input | AW | Value from the system bus for loading a pointer |
| din_val | input | AW | Bus input data register value |
| at_op | input | 2 | Derived-address register operation |
| ip_op | input | 2 | Instruction pointer operation |
| pf_op | input | 2 | Prefetch pointer operation |
| acc_type | input | 2 | Access type selecting the output source |
| addr_out | output | AW | Registered memory address |
| inc_err | output | 1 | Both pointers asked for the shared incrementer in the previous cycle |

## Verification
The assertions assume the operation and access-type inputs are free of X and unknown values once reset is released and change only between clock edges; the bench drives every input on the falling edge from defined values, starting at time zero. They also take the conflict case as legal input, so the stimulus produces simultaneous increment requests deliberately as well as at random. Since the pointers are visible only through the output mux, the bench chooses access types so that each pointer's content is read back after the operations that could have changed it.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {AT_HOLD = 2'd0, AT_BUS = 2'd1, AT_INC = 2'd2, AT_DIN = 2'd3} at_op_e;
  typedef enum logic [1:0] {IP_HOLD = 2'd0, IP_BUS = 2'd1, IP_INC = 2'd2, IP_KEEP = 2'd3} ip_op_e;
  typedef enum logic [1:0] {PF_HOLD = 2'd0, PF_COPY = 2'd1, PF_INC = 2'd2, PF_KEEP = 2'd3} pf_op_e;
  typedef enum logic [1:0] {ACC_EFF = 2'd0, ACC_JUMP = 2'd1, ACC_IND = 2'd2, ACC_PREF = 2'd3} acc_e;
endpackage

// File: rtl/agu_shared_inc.sv
module agu_shared_inc #(
  parameter int AW = 16
) (
  input  logic          ip_req,
  input  logic          at_req,
  input  logic [AW-1:0] ip_val,
  input  logic [AW-1:0] at_val,
  output logic [AW-1:0] sum,
  output logic          grant_ip,
  output logic          grant_at,
  output logic          clash
);
  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  logic [AW-1:0] operand;

  always_comb begin
    grant_ip = ip_req;
    grant_at = at_req && !ip_req;
    clash    = at_req && ip_req;
    operand  = ip_req ? ip_val : at_val;
    sum      = step_up(operand);
  end
endmodule

// File: rtl/agu_ptr_regs.sv
module agu_ptr_regs
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  at_op_e        at_op,
  input  ip_op_e        ip_op,
  input  pf_op_e        pf_op,
  input  logic [AW-1:0] sbus_val,
  input  logic [AW-1:0] din_val,
  input  logic [AW-1:0] inc_sum,
  input  logic          grant_ip,
  input  logic          grant_at,
  output logic [AW-1:0] at_q,
  output logic [AW-1:0] ic_q,
  output logic [AW-1:0] pf_q
);
  function automatic logic [AW-1:0] pf_step(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  logic [AW-1:0] at_d, ic_d, pf_d;

  always_comb begin
    at_d = at_q;
    case (at_op)
      AT_BUS:  at_d = sbus_val;
      AT_INC:  at_d = grant_at ? inc_sum : at_q;
      AT_DIN:  at_d = din_val;
      default: at_d = at_q;
    endcase
    ic_d = ic_q;
    case (ip_op)
      IP_BUS:  ic_d = sbus_val;
      IP_INC:  ic_d = grant_ip ? inc_sum : ic_q;
      default: ic_d = ic_q;
    endcase
    pf_d = pf_q;
    case (pf_op)
      PF_COPY: pf_d = ic_q;
      PF_INC:  pf_d = pf_step(pf_q);
      default: pf_d = pf_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      at_q <= '0;
      ic_q <= '0;
      pf_q <= '0;
    end else begin
      at_q <= at_d;
      ic_q <= ic_d;
      pf_q <= pf_d;
    end
  end

  // R3
  ic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_op == IP_HOLD || ip_op == IP_KEEP) |=> $stable(ic_q));

  // R4
  pf_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_op == PF_COPY) |=> (pf_q == $past(ic_q)));

  // R7
  clash_ip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_op == AT_INC && ip_op == IP_INC) |=> (ic_q == $past(ic_q) + AW'(1)) && $stable(at_q));

  // R2
  at_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_op == AT_DIN) |=> (at_q == $past(din_val)));
endmodule

// File: rtl/agu_out_sel.sv
module agu_out_sel
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_e          acc,
  input  logic [AW-1:0] at_i,
  input  logic [AW-1:0] ic_i,
  input  logic [AW-1:0] din_i,
  input  logic [AW-1:0] pf_i,
  input  logic          clash_i,
  output logic [AW-1:0] addr_q,
  output logic          err_q
);
  logic [AW-1:0] pick;

  always_comb begin
    case (acc)
      ACC_EFF:  pick = at_i;
      ACC_JUMP: pick = ic_i;
      ACC_IND:  pick = din_i;
      default:  pick = pf_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= pick;
      err_q  <= clash_i;
    end
  end

  // R5
  jump_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_JUMP) |=> (addr_q == $past(ic_i)));

  // R5
  pref_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_PREF) |=> (addr_q == $past(pf_i)));

  // R7
  clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_i |=> err_q);

  // R7
  no_clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clash_i |=> !err_q);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sbus_val,
  input  logic [AW-1:0] din_val,
  input  logic [1:0]    at_op,
  input  logic [1:0]    ip_op,
  input  logic [1:0]    pf_op,
  input  logic [1:0]    acc_type,
  output logic [AW-1:0] addr_out,
  output logic          inc_err
);
  at_op_e at_op_w;
  ip_op_e ip_op_w;
  pf_op_e pf_op_w;
  acc_e   acc_w;

  assign at_op_w = at_op_e'(at_op);
  assign ip_op_w = ip_op_e'(ip_op);
  assign pf_op_w = pf_op_e'(pf_op);
  assign acc_w   = acc_e'(acc_type);

  logic          at_inc_req, ip_inc_req;
  logic [AW-1:0] inc_sum;
  logic          grant_ip, grant_at, inc_clash;
  logic [AW-1:0] at_q, ic_q, pf_q;

  assign at_inc_req = (at_op_w == AT_INC);
  assign ip_inc_req = (ip_op_w == IP_INC);

  agu_shared_inc #(.AW(AW)) u_inc (
    .ip_req   (ip_inc_req),
    .at_req   (at_inc_req),
    .ip_val   (ic_q),
    .at_val   (at_q),
    .sum      (inc_sum),
    .grant_ip (grant_ip),
    .grant_at (grant_at),
    .clash    (inc_clash)
  );

  agu_ptr_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .at_op    (at_op_w),
    .ip_op    (ip_op_w),
    .pf_op    (pf_op_w),
    .sbus_val (sbus_val),
    .din_val  (din_val),
    .inc_sum  (inc_sum),
    .grant_ip (grant_ip),
    .grant_at (grant_at),
    .at_q     (at_q),
    .ic_q     (ic_q),
    .pf_q     (pf_q)
  );

  agu_out_sel #(.AW(AW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc_w),
    .at_i    (at_q),
    .ic_i    (ic_q),
    .din_i   (din_val),
    .pf_i    (pf_q),
    .clash_i (inc_clash),
    .addr_q  (addr_out),
    .err_q   (inc_err)
  );

  // R6
  ic_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_op_w == IP_INC && ic_q == {AW{1'b1}}) |=> (u_regs.ic_q == '0));
endmodule

// File: tb/agu_top_bench.sv
module agu_top_bench;
  localparam int AW = 16;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] sbus_val = '0;
  logic [AW-1:0] din_val = '0;
  logic [1:0]    at_op = 2'd0;
  logic [1:0]    ip_op = 2'd0;
  logic [1:0]    pf_op = 2'd0;
  logic [1:0]    acc_type = 2'd3;
  logic [AW-1:0] addr_out;
  logic          inc_err;

  int compared = 0;
  int mismatched = 0;
  bit checking = 1'b0;
  string cur_req = "R1";

  int m_at = 0, m_ic = 0, m_pf = 0, m_addr = 0;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  agu_top #(.AW(AW)) u_agu_top (
    .clk(clk), .rst_n(rst_n), .sbus_val(sbus_val), .din_val(din_val),
    .at_op(at_op), .ip_op(ip_op), .pf_op(pf_op), .acc_type(acc_type),
    .addr_out(addr_out), .inc_err(inc_err)
  );

  // behavioural reference: every value from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_at = 0; m_ic = 0; m_pf = 0; m_addr = 0; m_err = 1'b0;
    end else begin
      int n_at, n_ic, n_pf;
      bit both;
      if (acc_type == 2'd0) m_addr = m_at;
      else if (acc_type == 2'd1) m_addr = m_ic;
      else if (acc_type == 2'd2) m_addr = int'(din_val);
      else m_addr = m_pf;
      both = (at_op == 2'd2) && (ip_op == 2'd2);
      m_err = both;
      n_at = m_at; n_ic = m_ic; n_pf = m_pf;
      if (at_op == 2'd1) n_at = int'(sbus_val);
      else if (at_op == 2'd2 && !both) n_at = (m_at + 1) & MASK;
      else if (at_op == 2'd3) n_at = int'(din_val);
      if (ip_op == 2'd1) n_ic = int'(sbus_val);
      else if (ip_op == 2'd2) n_ic = (m_ic + 1) & MASK;
      if (pf_op == 2'd1) n_pf = m_ic;
      else if (pf_op == 2'd2) n_pf = (m_pf + 1) & MASK;
      m_at = n_at; m_ic = n_ic; m_pf = n_pf;
    end
  end

  task automatic check_now(string req);
    compared++;
    if (int'(addr_out) != m_addr || inc_err != m_err) begin
      mismatched++;
      $display("FAIL %s: addr_out=%h err=%0b expected addr_out=%h err=%0b",
               req, addr_out, inc_err, m_addr[AW-1:0], m_err);
    end
  endtask

  always @(negedge clk) if (checking) check_now(cur_req);

  task automatic step(input int a, input int i, input int p, input int s,
                      input int bus, input int din);
    at_op = 2'(a); ip_op = 2'(i); pf_op = 2'(p); acc_type = 2'(s);
    sbus_val = AW'(bus); din_val = AW'(din);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected end before limit");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_now("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R1");
    checking = 1'b1;

    // R2: derived-address register loads and increment
    cur_req = "R2";
    step(1, 0, 0, 0, 16'h1234, 0);
    step(2, 0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 16'hBEEF);
    step(0, 0, 0, 0, 16'h5555, 16'h7777);
    step(0, 0, 0, 0, 0, 0);

    // R3: instruction pointer load, increment, hold
    cur_req = "R3";
    step(0, 1, 0, 1, 16'h0100, 0);
    step(0, 2, 0, 1, 0, 0);
    step(0, 0, 0, 1, 16'h9999, 0);
    step(0, 0, 0, 1, 0, 0);

    // R4: prefetch pointer copy and increment
    cur_req = "R4";
    step(0, 0, 1, 3, 0, 0);
    step(0, 0, 2, 3, 0, 0);
    step(0, 0, 2, 3, 0, 0);
    step(0, 0, 0, 3, 0, 0);

    // R5: every access type in turn
    cur_req = "R5";
    step(1, 0, 0, 0, 16'hA0A0, 16'h0C0C);
    step(0, 0, 0, 2, 0, 16'h0C0D);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 3, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R6: wrap of every incremented pointer
    cur_req = "R6";
    step(1, 1, 0, 1, 16'hFFFF, 0);
    step(0, 2, 1, 1, 0, 0);
    step(2, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 16'hFFFF, 0);
    step(0, 0, 1, 3, 0, 0);
    step(0, 0, 2, 3, 0, 0);
    step(0, 0, 0, 3, 0, 0);

    // R7: simultaneous increment requests
    cur_req = "R7";
    step(1, 1, 0, 0, 16'h0040, 0);
    step(2, 2, 0, 0, 0, 0);
    step(2, 2, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);

    // R8: code 3 holds the instruction and prefetch pointers
    cur_req = "R8";
    step(0, 1, 1, 1, 16'h3210, 0);
    step(0, 3, 3, 1, 16'h1111, 0);
    step(0, 3, 3, 3, 16'h2222, 0);
    step(0, 0, 0, 1, 0, 0);

    // R5: mixed random traffic
    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      step($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), (k % 7 == 0) ? 16'hFFFE : $urandom_range(0, MASK),
           $urandom_range(0, MASK));
    end

    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule